// File: doc/BRIEF.md
# Two-Wire Clock Enable Controller

This block is the control side of a one-to-ten clock fan-out. A bus master writes per-output enable bits over a two-wire serial bus (I2C-style signalling). The block only receives and cannot be read. The block samples the serial clock and data lines with its own system clock, finds start and stop conditions, and checks the first byte against a fixed slave address with the write direction. It acknowledges that byte and every byte after it. The two bytes that follow the address are acknowledged and thrown away. Each later data byte is stored in the next enable register, starting at register 0. There is no register pointer, so reaching register 2 means sending registers 0 and 1 again first.

The ten clock outputs are copies of one reference clock input. Each copy is gated by its enable bit, and a disabled output sits at 0. An active-low output-enable input removes the drive from all ten outputs at once, whatever the registers hold. The serial data line is open-drain. The block gives only a pull-low enable and never drives a 1.

Top module: `clk_fanout_en_ctrl`

## Requirements
- R1: After reset all ten enables are 1, so every output follows the reference clock, and `sda_oe_o` is 0.
- R2: The first byte after a start is acknowledged only when it equals 0xD2, which is address 0x69 with a write bit of 0. The acknowledge is `sda_oe_o` = 1 during the ninth SCL high phase. Any other first byte, including the read form 0xD3, gets no acknowledge, and nothing is written until the next start.
- R3: A start (SDA falling while SCL is high) restarts at the address byte from any state. A stop (SDA rising while SCL is high) ends the transfer, and bytes clocked after it without a new start are neither acknowledged nor stored.
- R4: The two bytes after an accepted address are acknowledged, and their values reach no register.
- R5: Data bytes are written to register 0, then 1, then 2. A transfer that ends early leaves the enables of the registers it did not reach unchanged.
- R6: Register 0 bits 3..0 enable outputs 3..0. Register 1 bits 7..4 enable outputs 7..4. Register 2 bits 7..6 enable outputs 9..8. All other bits have no effect.
- R7: Data bytes after the third are acknowledged and change no enable.
- R8: `clk_out_o[i]` equals the reference clock when enable i is 1, and is held at 0 when enable i is 0.
- R9: `clk_out_drv_o` is all 1 when `oe_n_i` is 1 and all 0 when `oe_n_i` is 0, whatever the enables hold.
- R10: `sda_oe_o` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge) |
| ref_clk_i | input | 1 | Reference clock to be fanned out |
| oe_n_i | input | 1 | Active-low drive enable for all outputs |
| clk_out_o | output | 10 | Gated copies of the reference clock |
| clk_out_drv_o | output | 10 | Per-output drive enable, 0 means high-impedance |

## Verification
A bus edge passes through two synchronizer flops and one compare against the held previous value. The state machine therefore registers its response on the third system-clock edge after the line changes. An enable changes one edge later, which is about four system cycles after the SCL falling edge that ends a data byte. The acknowledge rises at that same point and falls the same number of cycles after the falling edge of the ninth pulse. The bench holds each SCL phase for 16 system cycles. It samples the acknowledge in the middle of the ninth high phase and reads the enables at least four cycles after the stop, both well clear of these latencies. The gated outputs and drive enables are combinational from the reference clock, the output-enable pin and the enable flops. They are checked one time step after the inputs change, between clock edges.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

  localparam int unsigned NUM_OUT  = 10;
  localparam int unsigned NUM_REGS = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BITS,
    ST_WAIT_LOW,
    ST_ACK_LOW,
    ST_ACK_HIGH
  } rx_state_t;

  // Register that holds the enable of output o.
  function automatic int unsigned en_reg_of(input int unsigned o);
    if (o < 4)      return 0;
    else if (o < 8) return 1;
    else            return 2;
  endfunction

  // Bit inside that register.
  function automatic int unsigned en_bit_of(input int unsigned o);
    if (o < 8) return o;
    else       return o - 2;
  endfunction

endpackage

// File: rtl/clkfan_rst_sync.sv
module clkfan_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/clkfan_line_sync.sv
module clkfan_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe_q, scl_pipe_d;
  logic [STAGES-1:0] sda_pipe_q, sda_pipe_d;
  logic              scl_prev_q, sda_prev_q;

  always_comb begin
    scl_pipe_d = {scl_pipe_q[STAGES-2:0], scl_i};
    sda_pipe_d = {sda_pipe_q[STAGES-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign scl_s     = scl_pipe_q[STAGES-1];
  assign sda_s     = sda_pipe_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  assign start_evt = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_evt  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/clkfan_i2c_rx.sv
module clkfan_i2c_rx
  import clkfan_pkg::*;
#(
  parameter logic [6:0]  SLAVE_ADDR  = 7'h69,
  parameter int unsigned DUMMY_BYTES = 2,
  parameter int unsigned REGS        = NUM_REGS,
  localparam int unsigned FIRST_DATA = 1 + DUMMY_BYTES,
  localparam int unsigned LAST_IDX   = FIRST_DATA + REGS,
  localparam int unsigned IDX_W      = $clog2(LAST_IDX + 1),
  localparam int unsigned REG_W      = (REGS > 1) ? $clog2(REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_s,
  input  logic             start_evt,
  input  logic             stop_evt,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [REG_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o
);
  rx_state_t        state_q, state_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       shift_q, shift_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             oe_q, oe_d;
  logic             wr_q, wr_d;
  logic [REG_W-1:0] widx_q, widx_d;
  logic [7:0]       wdat_q, wdat_d;
  logic             accept;
  logic [IDX_W-1:0] rel_idx;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    shift_d = shift_q;
    idx_d   = idx_q;
    wr_d    = 1'b0;
    widx_d  = widx_q;
    wdat_d  = wdat_q;
    accept  = 1'b0;
    rel_idx = idx_q - IDX_W'(FIRST_DATA);

    if (stop_evt) begin
      state_d = ST_IDLE;
    end else if (start_evt) begin
      state_d = ST_BITS;
      bit_d   = 3'd0;
      idx_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_BITS: begin
          if (scl_rise) begin
            shift_d = {shift_q[6:0], sda_s};
            bit_d   = bit_q + 3'd1;
            if (bit_q == 3'd7) state_d = ST_WAIT_LOW;
          end
        end
        ST_WAIT_LOW: begin
          if (scl_fall) begin
            accept = (idx_q != '0) || (shift_q == {SLAVE_ADDR, 1'b0});
            if (accept) begin
              state_d = ST_ACK_LOW;
              if (idx_q >= IDX_W'(FIRST_DATA) && idx_q < IDX_W'(LAST_IDX)) begin
                wr_d   = 1'b1;
                widx_d = REG_W'(rel_idx);
                wdat_d = shift_q;
              end
              if (idx_q != IDX_W'(LAST_IDX)) idx_d = idx_q + 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ACK_LOW: begin
          if (scl_rise) state_d = ST_ACK_HIGH;
        end
        ST_ACK_HIGH: begin
          if (scl_fall) begin
            state_d = ST_BITS;
            bit_d   = 3'd0;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
    oe_d = (state_d == ST_ACK_LOW) || (state_d == ST_ACK_HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= 3'd0;
      shift_q <= 8'h00;
      idx_q   <= '0;
      oe_q    <= 1'b0;
      wr_q    <= 1'b0;
      widx_q  <= '0;
      wdat_q  <= 8'h00;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
      idx_q   <= idx_d;
      oe_q    <= oe_d;
      wr_q    <= wr_d;
      widx_q  <= widx_d;
      wdat_q  <= wdat_d;
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = wr_q;
  assign wr_idx_o  = widx_q;
  assign wr_data_o = wdat_q;
endmodule

// File: rtl/clkfan_en_regs.sv
module clkfan_en_regs
  import clkfan_pkg::*;
#(
  parameter int unsigned REGS = NUM_REGS,
  localparam int unsigned REG_W = (REGS > 1) ? $clog2(REGS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_idx,
  input  logic [7:0]         wr_data,
  output logic [NUM_OUT-1:0] en_o
);
  logic [NUM_OUT-1:0] en_q, en_d;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_en
    localparam int unsigned RSEL = en_reg_of(g);
    localparam int unsigned BSEL = en_bit_of(g);
    always_comb begin
      if (wr_en && (wr_idx == REG_W'(RSEL))) en_d[g] = wr_data[BSEL];
      else                                   en_d[g] = en_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '1;
    else        en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/clk_fanout_en_ctrl.sv
module clk_fanout_en_ctrl
  import clkfan_pkg::*;
#(
  parameter logic [6:0]  SLAVE_ADDR  = 7'h69,
  parameter int unsigned DUMMY_BYTES = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned REG_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic               ref_clk_i,
  input  logic               oe_n_i,
  output logic [NUM_OUT-1:0] clk_out_o,
  output logic [NUM_OUT-1:0] clk_out_drv_o
);
  logic               sys_rst_n;
  logic               scl_s_w, sda_s_w, scl_rise_w, scl_fall_w;
  logic               start_w, stop_w;
  logic               wr_en_w;
  logic [REG_W-1:0]   wr_idx_w;
  logic [7:0]         wr_data_w;
  logic [NUM_OUT-1:0] en_w;

  clkfan_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (sys_rst_n)
  );

  clkfan_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (sys_rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s_w),
    .sda_s     (sda_s_w),
    .scl_rise  (scl_rise_w),
    .scl_fall  (scl_fall_w),
    .start_evt (start_w),
    .stop_evt  (stop_w)
  );

  clkfan_i2c_rx #(
    .SLAVE_ADDR  (SLAVE_ADDR),
    .DUMMY_BYTES (DUMMY_BYTES),
    .REGS        (NUM_REGS)
  ) u_rx (
    .clk       (clk),
    .rst_n     (sys_rst_n),
    .scl_rise  (scl_rise_w),
    .scl_fall  (scl_fall_w),
    .sda_s     (sda_s_w),
    .start_evt (start_w),
    .stop_evt  (stop_w),
    .sda_oe_o  (sda_oe_o),
    .wr_en_o   (wr_en_w),
    .wr_idx_o  (wr_idx_w),
    .wr_data_o (wr_data_w)
  );

  clkfan_en_regs #(.REGS(NUM_REGS)) u_regs (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .wr_en   (wr_en_w),
    .wr_idx  (wr_idx_w),
    .wr_data (wr_data_w),
    .en_o    (en_w)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    assign clk_out_o[g]     = ref_clk_i & en_w[g];
    assign clk_out_drv_o[g] = oe_n_i;
  end
endmodule

// File: rtl/clk_fanout_en_ctrl_chk.sv
module clk_fanout_en_ctrl_chk #(
  parameter int unsigned N = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sda_oe_o,
  input logic         scl_s,
  input logic         stop_evt,
  input logic         wr_en,
  input logic [N-1:0] en,
  input logic [N-1:0] clk_out_o
);
  // R10: acknowledge drive starts and ends only while SCL is low
  p_ack_rise_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_s);
  p_ack_fall_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> !scl_s);
  // R5: enables move only in the cycle after a register write
  p_en_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en));
  // R4: every write belongs to an acknowledged byte
  p_write_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> sda_oe_o);
  // R3: a stop leaves no acknowledge driven
  p_stop_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe_o);
  // R8: a disabled output never shows a high level
  p_disabled_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_out_o & ~en) == '0);
endmodule

bind clk_fanout_en_ctrl clk_fanout_en_ctrl_chk #(.N(10)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_oe_o  (sda_oe_o),
  .scl_s     (scl_s_w),
  .stop_evt  (stop_w),
  .wr_en     (wr_en_w),
  .en        (en_w),
  .clk_out_o (clk_out_o)
);

// File: tb/clk_fanout_en_ctrl_tb.sv
module clk_fanout_en_ctrl_tb;
  localparam int Q = 8;  // quarter SCL period in system cycles

  logic       clk = 1'b0;
  logic       rst_n;
  logic       m_scl, m_sda;
  logic       sda_line;
  logic       sda_oe_o;
  logic       ref_clk_i, oe_n_i;
  logic [9:0] clk_out_o, clk_out_drv_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe_o;

  clk_fanout_en_ctrl u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (m_scl),
    .sda_i         (sda_line),
    .sda_oe_o      (sda_oe_o),
    .ref_clk_i     (ref_clk_i),
    .oe_n_i        (oe_n_i),
    .clk_out_o     (clk_out_o),
    .clk_out_drv_o (clk_out_drv_o)
  );

  // {byte0..byte4, data byte count, expected enables}
  localparam int NV = 6;
  localparam logic [52:0] VEC [NV] = '{
    {40'h0550800000, 3'd3, 10'h255},
    {40'hFFFFFF0000, 3'd3, 10'h3FF},
    {40'h0A00000000, 3'd1, 10'h3FA},
    {40'h0030000000, 3'd2, 10'h330},
    {40'hF00F400000, 3'd3, 10'h100},
    {40'h0CA0C0FFFF, 3'd5, 10'h3AC}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_en(input string req, input logic [9:0] exp);
    @(negedge clk);
    ref_clk_i = 1'b1;
    #1 check(req, 32'(clk_out_o), 32'(exp));
    ref_clk_i = 1'b0;
    #1 check(req, 32'(clk_out_o), 32'h0);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic i2c_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = d[i]; tick(Q);
      m_scl = 1'b1; tick(2 * Q);
      m_scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    ack = ~sda_line;
    tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic ack, all_ack;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; ref_clk_i = 1'b0; oe_n_i = 1'b1;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1: reset state
    check("R1 sda_oe after reset", 32'(sda_oe_o), 32'h0);
    check_en("R1 enables after reset", 10'h3FF);
    check("R9 drive with oe_n=1", 32'(clk_out_drv_o), 32'h3FF);

    // Vector table: R2 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      logic [39:0] bytes;
      logic [2:0]  cnt;
      logic [9:0]  exp;
      {bytes, cnt, exp} = VEC[v];
      all_ack = 1'b1;
      i2c_start();
      i2c_byte(8'hD2, ack); check("R2 address 0xD2 acknowledged", 32'(ack), 32'h1);
      i2c_byte(8'h00, ack); all_ack &= ack;
      i2c_byte(8'hA5, ack); all_ack &= ack;
      for (int b = 0; b < 5; b++) begin
        if (b < int'(cnt)) begin
          i2c_byte(bytes[39 - 8*b -: 8], ack);
          all_ack &= ack;
        end
      end
      i2c_stop();
      tick(4);
      check("R4 R7 dummy and data bytes acknowledged", 32'(all_ack), 32'h1);
      check_en($sformatf("R5 R6 R8 vector %0d enables", v), exp);
    end

    // R2: wrong address ignored
    i2c_start();
    i2c_byte(8'hD4, ack); check("R2 wrong address not acknowledged", 32'(ack), 32'h0);
    i2c_byte(8'h00, ack); i2c_byte(8'h00, ack); i2c_byte(8'h00, ack);
    check("R2 bytes after wrong address not acknowledged", 32'(ack), 32'h0);
    i2c_stop(); tick(4);
    check_en("R2 wrong address leaves enables", 10'h3AC);

    // R2: read request ignored
    i2c_start();
    i2c_byte(8'hD3, ack); check("R2 read request not acknowledged", 32'(ack), 32'h0);
    i2c_byte(8'h00, ack); i2c_byte(8'h00, ack); i2c_byte(8'h00, ack);
    i2c_stop(); tick(4);
    check_en("R2 read request leaves enables", 10'h3AC);

    // R3: repeated start restarts the sequence at the address byte
    i2c_start();
    i2c_byte(8'hD2, ack);
    i2c_byte(8'h00, ack);
    i2c_start();
    i2c_byte(8'hD2, ack); check("R3 address after repeated start", 32'(ack), 32'h1);
    i2c_byte(8'hFF, ack); i2c_byte(8'hFF, ack);
    i2c_byte(8'h03, ack);
    i2c_stop(); tick(4);
    check_en("R3 repeated start enables", 10'h3A3);

    // R3: bytes after stop without a start are ignored
    i2c_byte(8'hD2, ack); check("R3 no acknowledge after stop", 32'(ack), 32'h0);
    i2c_byte(8'h00, ack); i2c_byte(8'h00, ack); i2c_byte(8'h00, ack);
    tick(4);
    check_en("R3 enables unchanged after stop", 10'h3A3);
    i2c_stop();

    // R9: output enable pin
    @(negedge clk); oe_n_i = 1'b0;
    #1 check("R9 drive with oe_n=0", 32'(clk_out_drv_o), 32'h0);
    @(negedge clk); oe_n_i = 1'b1;
    #1 check("R9 drive restored", 32'(clk_out_drv_o), 32'h3FF);

    // R1: reset restores all enables
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(4);
    check_en("R1 enables after second reset", 10'h3FF);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule